// File: doc/BRIEF.md
# Flash Read Response Multiplexer

This block forms the read reply of a parallel NOR flash command interface. A command decoder elsewhere holds the current command mode. On every read strobe this block looks at that mode and returns one of four kinds of data:

- array contents fetched from an external synchronous memory;
- the status byte, repeated across the device lanes;
- manufacturer and device identifier codes;
- bytes of a read-only parameter table.

Bank width, device width, maximum device width and byte order are static configuration inputs. The block maps the narrow reply of a single device onto the full bank width. It also splits an access that is wider than one bank into bank-sized slices.

The reply is registered. It appears in the cycle after the strobe, qualified by a valid pulse. When the mode is not recognised, the block falls back to an array read and pulses a clear request back to the command decoder. The decoder then resets its mode and write-cycle state.

Top module: `flash_rd_mux`

## Requirements
- R1: `rd_valid` is high in exactly the cycle after a cycle with `rd_req` high, and low in every other cycle, including during reset. `rd_data` is valid while `rd_valid` is high.
- R2: In mode 0x00 the reply is the array bytes starting at `rd_addr`. The access size code is 0 for 1 byte, 1 for 2 bytes, and 2 or 3 for 4 bytes. With `big_endian` low, the byte at the lowest address lands in bits 7:0.
- R3: With `big_endian` high, an array reply places the byte at the lowest address in the most significant byte of the access.
- R4: Modes 0x10, 0x20, 0x28, 0x40, 0x50, 0x60, 0x70 and 0xE8 return the status byte. Device-width codes 1, 2 and 3 mean 1, 2 and 4 bytes. The status byte sits in the low byte of every device-width lane inside the access, and the other bytes are zero.
- R5: With device-width code 0 (legacy), a status reply of 4 bytes carries the status byte in bits 7:0 and bits 23:16. Smaller accesses carry it in bits 7:0 only.
- R6: In every mode, bytes above the access size read as zero.
- R7: In mode 0x98, a device of width D in a bank of width B (bank code 0/1/2 means 1/2/4 bytes) reads table entry addr >> (log2 B + log2 M − log2 D). M is the maximum device width; maximum-width code 0 means M = D. When D equals M, the entry is zero-extended to D bytes and copied into each D-byte lane of the bank. Table index:value (hex): 10:51 11:52 12:59 13:01 15:31 1B:45 1C:55 1F:07 20:07 21:0A 23:04 24:04 25:04 27:16 28:02 2A:0B 2C:01 2D:3F 2E:00 2F:00 30:01 31:50 32:52 33:49 34:31 35:30 3F:01. All other entries are zero.
- R8: A table index greater than 0x52 reads as zero.
- R9: When D is below M, the entry is copied into every byte of the bank if D is 1. Otherwise the reply is zero.
- R10: In mode 0x90 the index is computed as in R7 and only its low 8 bits are used. Index 0 gives the 16-bit `id_mfr`, index 1 gives `id_dev`, and any other index gives zero. The low D bytes of that value are copied into every D-byte lane of the bank.
- R11: In legacy width, the index is `rd_addr[7:0]` shifted right by the bank code. Mode 0x90 returns {`id_mfr[7:0]`,`id_dev[7:0]`} at index 0, {`id_aux0`,`id_aux1`} at index 1, and zero at any other index. Mode 0x98 returns the table byte directly.
- R12: In non-legacy width, an access wider than the bank is answered as slices. Slice k fills bytes k·B upward and is looked up at `rd_addr` + k·B.
- R13: Any mode not listed above is answered as an array read, and `mode_clr` pulses together with that reply. `mode_clr` stays low at all other times.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| rd_req | input | 1 | Read strobe |
| rd_addr | input | ADDR_W | Byte address of the access |
| rd_size | input | 2 | Access size code (0:1, 1:2, 2/3:4 bytes) |
| rd_mode | input | 8 | Current command mode from the decoder |
| bank_code | input | 2 | Bank width code (0:1, 1:2, 2/3:4 bytes) |
| dev_code | input | 2 | Device width code (0 legacy, 1:1, 2:2, 3:4 bytes) |
| max_code | input | 2 | Maximum device width code (0 = same as device) |
| big_endian | input | 1 | Byte order for array replies |
| status | input | 8 | Current status byte |
| id_mfr | input | 16 | Manufacturer code |
| id_dev | input | 16 | Device code |
| id_aux0 | input | 8 | Legacy second-pair high code |
| id_aux1 | input | 8 | Legacy second-pair low code |
| arr_rd_en | output | 1 | Array memory read enable |
| arr_addr | output | ADDR_W | Array memory byte address |
| arr_rdata | input | 32 | Array bytes addr..addr+3 (lowest in bits 7:0), one cycle after enable |
| rd_valid | output | 1 | Reply valid |
| rd_data | output | 32 | Reply data |
| mode_clr | output | 1 | Request to clear mode and cycle state |

## Verification
The bench sweeps every legal width combination, six modes, three access sizes and more than a hundred addresses. The addresses are chosen so that the table index crosses 0x52 at every shift amount. An index that wrapped instead of saturating would return 'Q' where zero is expected.

A shift amount that ignored the maximum device width would read the wrong table entry whenever the maximum exceeds the device width. Slicing errors show up as correct low bytes with upper slices repeated from slice 0 instead of the neighbouring address.

Legacy status with a 4-byte access catches a design that copies status into every byte. A missing mask above the access size shows up in the directed legacy identifier read of one byte. An unknown mode that is not redirected to the array, or that omits the clear pulse, fails both the data check and the `mode_clr` check.

// File: rtl/frm_pkg.sv
`timescale 1ns/1ps
package frm_pkg;
   localparam logic [7:0] M_ARRAY = 8'h00;
   localparam logic [7:0] M_IDENT = 8'h90;
   localparam logic [7:0] M_QUERY = 8'h98;
   localparam int unsigned QTBL_LAST = 32'h52;
   localparam int unsigned QIDX_W = $clog2(QTBL_LAST + 1);

   function automatic logic is_status_mode(input logic [7:0] m);
      case (m)
         8'h10, 8'h20, 8'h28, 8'h40, 8'h50, 8'h60, 8'h70, 8'hE8: return 1'b1;
         default: return 1'b0;
      endcase
   endfunction

   function automatic logic is_known_mode(input logic [7:0] m);
      return (m == M_ARRAY) || (m == M_IDENT) || (m == M_QUERY) || is_status_mode(m);
   endfunction

   function automatic logic [2:0] size_bytes(input logic [1:0] code);
      case (code)
         2'd0: return 3'd1;
         2'd1: return 3'd2;
         default: return 3'd4;
      endcase
   endfunction

   // keep bytes below 'total', each byte b taken from byte (b mod 2**unit_lg) of v
   function automatic logic [31:0] lane_fill(input logic [31:0] v, input logic [1:0] unit_lg,
                                             input logic [2:0] total);
      logic [31:0] r;
      int um;
      um = (1 << unit_lg) - 1;
      for (int b = 0; b < 4; b++)
         r[8*b +: 8] = (b < int'(total)) ? v[8*(b & um) +: 8] : 8'h00;
      return r;
   endfunction

   function automatic logic [31:0] size_mask(input logic [2:0] nb);
      logic [31:0] r;
      for (int b = 0; b < 4; b++)
         r[8*b +: 8] = (b < int'(nb)) ? 8'hFF : 8'h00;
      return r;
   endfunction
endpackage

// File: rtl/frm_qrom.sv
`timescale 1ns/1ps
module frm_qrom #(
   parameter int unsigned SECTOR_LG = 16,
   parameter int unsigned BLOCKS    = 64,
   parameter int unsigned WBUF_LG   = 11
) (
   input  logic [frm_pkg::QIDX_W-1:0] idx,
   output logic [7:0]                 val
);
   localparam int unsigned BLK_M1     = BLOCKS - 1;
   localparam int unsigned SECT_BYTES = 1 << SECTOR_LG;
   localparam logic [7:0]  TOTAL_LG   = 8'(SECTOR_LG + $clog2(BLOCKS));

   always_comb begin
      case (idx)
         7'h10: val = 8'h51;
         7'h11: val = 8'h52;
         7'h12: val = 8'h59;
         7'h13: val = 8'h01;
         7'h15: val = 8'h31;
         7'h1B: val = 8'h45;
         7'h1C: val = 8'h55;
         7'h1F: val = 8'h07;
         7'h20: val = 8'h07;
         7'h21: val = 8'h0A;
         7'h23, 7'h24, 7'h25: val = 8'h04;
         7'h27: val = TOTAL_LG;
         7'h28: val = 8'h02;
         7'h2A: val = 8'(WBUF_LG);
         7'h2C: val = 8'h01;
         7'h2D: val = 8'(BLK_M1 & 32'hFF);
         7'h2E: val = 8'((BLK_M1 >> 8) & 32'hFF);
         7'h2F: val = 8'((SECT_BYTES >> 8) & 32'hFF);
         7'h30: val = 8'((SECT_BYTES >> 16) & 32'hFF);
         7'h31: val = 8'h50;
         7'h32: val = 8'h52;
         7'h33: val = 8'h49;
         7'h34: val = 8'h31;
         7'h35: val = 8'h30;
         7'h3F: val = 8'h01;
         default: val = 8'h00;
      endcase
   end
endmodule

// File: rtl/frm_slice.sv
`timescale 1ns/1ps
module frm_slice #(
   parameter int unsigned ADDR_W    = 16,
   parameter int unsigned SECTOR_LG = 16,
   parameter int unsigned BLOCKS    = 64,
   parameter int unsigned WBUF_LG   = 11
) (
   input  logic [ADDR_W-1:0] addr,
   input  logic [1:0]        bank_lg,
   input  logic [1:0]        dev_lg,
   input  logic [1:0]        max_lg,
   input  logic              want_query,
   input  logic [15:0]       id_mfr,
   input  logic [15:0]       id_dev,
   output logic [31:0]       resp
);
   import frm_pkg::*;

   logic [2:0]        shamt;
   logic [ADDR_W-1:0] idx;
   logic              over;
   logic [7:0]        tbyte;
   logic [31:0]       narrow;

   assign shamt = {1'b0, bank_lg} + {1'b0, max_lg} - {1'b0, dev_lg};
   assign idx   = addr >> shamt;
   assign over  = idx > ADDR_W'(QTBL_LAST);

   frm_qrom #(.SECTOR_LG(SECTOR_LG), .BLOCKS(BLOCKS), .WBUF_LG(WBUF_LG)) u_rom (
      .idx(idx[QIDX_W-1:0]),
      .val(tbyte)
   );

   always_comb begin
      if (want_query) begin
         if (over)
            narrow = '0;
         else if (dev_lg != max_lg)
            narrow = (dev_lg == 2'd0) ? lane_fill({24'h0, tbyte}, 2'd0, 3'(3'd1 << max_lg)) : '0;
         else
            narrow = {24'h0, tbyte};
      end else begin
         if (idx[7:0] == 8'd0)      narrow = {16'h0, id_mfr};
         else if (idx[7:0] == 8'd1) narrow = {16'h0, id_dev};
         else                       narrow = '0;
      end
      resp = lane_fill(narrow, dev_lg, 3'(3'd1 << bank_lg));
   end
endmodule

// File: rtl/flash_rd_mux.sv
`timescale 1ns/1ps
module flash_rd_mux #(
   parameter int unsigned ADDR_W    = 16,
   parameter int unsigned SECTOR_LG = 16,
   parameter int unsigned BLOCKS    = 64,
   parameter int unsigned WBUF_LG   = 11
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              rd_req,
   input  logic [ADDR_W-1:0] rd_addr,
   input  logic [1:0]        rd_size,
   input  logic [7:0]        rd_mode,
   input  logic [1:0]        bank_code,
   input  logic [1:0]        dev_code,
   input  logic [1:0]        max_code,
   input  logic              big_endian,
   input  logic [7:0]        status,
   input  logic [15:0]       id_mfr,
   input  logic [15:0]       id_dev,
   input  logic [7:0]        id_aux0,
   input  logic [7:0]        id_aux1,
   output logic              arr_rd_en,
   output logic [ADDR_W-1:0] arr_addr,
   input  logic [31:0]       arr_rdata,
   output logic              rd_valid,
   output logic [31:0]       rd_data,
   output logic              mode_clr
);
   import frm_pkg::*;

   localparam int unsigned NSLICE = 4;

   if (ADDR_W < 8 || ADDR_W > 32) begin : g_bad_addr
      $error("flash_rd_mux: ADDR_W must lie in 8..32");
   end
   if (SECTOR_LG < 8 || SECTOR_LG > 24) begin : g_bad_sector
      $error("flash_rd_mux: SECTOR_LG must lie in 8..24");
   end
   if (BLOCKS < 1 || BLOCKS > 65536) begin : g_bad_blocks
      $error("flash_rd_mux: BLOCKS must lie in 1..65536");
   end

   logic [1:0]  bl, dl, ml;
   logic [2:0]  nb;
   logic        legacy, known, arr_path;
   logic [31:0] placed [NSLICE];
   logic [31:0] slice_or, resp, resp_m;
   logic [7:0]  lidx, lrom;
   logic [15:0] leg_id;

   assign bl       = (bank_code == 2'd3) ? 2'd2 : bank_code;
   assign legacy   = (dev_code == 2'd0);
   assign dl       = dev_code - 2'd1;
   assign ml       = (max_code == 2'd0) ? dl : (max_code - 2'd1);
   assign nb       = size_bytes(rd_size);
   assign known    = is_known_mode(rd_mode);
   assign arr_path = !known || (rd_mode == M_ARRAY);

   for (genvar k = 0; k < NSLICE; k++) begin : g_slice
      logic [3:0]        s_base;
      logic [ADDR_W-1:0] s_addr;
      logic [31:0]       s_resp;
      assign s_base = 4'(k) << bl;
      assign s_addr = rd_addr + ADDR_W'(s_base);
      frm_slice #(.ADDR_W(ADDR_W), .SECTOR_LG(SECTOR_LG), .BLOCKS(BLOCKS),
                  .WBUF_LG(WBUF_LG)) u_slice (
         .addr(s_addr), .bank_lg(bl), .dev_lg(dl), .max_lg(ml),
         .want_query(rd_mode == M_QUERY), .id_mfr(id_mfr), .id_dev(id_dev),
         .resp(s_resp)
      );
      assign placed[k] = ({1'b0, s_base} < {2'b0, nb}) ? (s_resp << (8 * s_base)) : '0;
   end

   always_comb begin
      slice_or = '0;
      for (int k = 0; k < NSLICE; k++) slice_or = slice_or | placed[k];
   end

   // legacy width path: byte-wide index, no slicing
   assign lidx = rd_addr[7:0] >> bl;
   frm_qrom #(.SECTOR_LG(SECTOR_LG), .BLOCKS(BLOCKS), .WBUF_LG(WBUF_LG)) u_lrom (
      .idx(lidx[QIDX_W-1:0]),
      .val(lrom)
   );
   always_comb begin
      if (lidx == 8'd0)      leg_id = {id_mfr[7:0], id_dev[7:0]};
      else if (lidx == 8'd1) leg_id = {id_aux0, id_aux1};
      else                   leg_id = '0;
   end

   always_comb begin
      if (is_status_mode(rd_mode))
         resp = lane_fill({24'h0, status}, legacy ? 2'd1 : dl, nb);
      else if (rd_mode == M_IDENT)
         resp = legacy ? {16'h0, leg_id} : slice_or;
      else if (rd_mode == M_QUERY)
         resp = legacy ? ((32'(lidx) > QTBL_LAST) ? 32'h0 : {24'h0, lrom}) : slice_or;
      else
         resp = '0;
      resp_m = resp & size_mask(nb);
   end

   assign arr_rd_en = rd_req && arr_path;
   assign arr_addr  = rd_addr;

   logic        valid_q, arr_sel_q, be_q, clr_q;
   logic [2:0]  nb_q;
   logic [31:0] data_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         valid_q   <= 1'b0;
         arr_sel_q <= 1'b0;
         be_q      <= 1'b0;
         clr_q     <= 1'b0;
         nb_q      <= 3'd1;
         data_q    <= '0;
      end else begin
         valid_q <= rd_req;
         clr_q   <= rd_req && !known;
         if (rd_req) begin
            arr_sel_q <= arr_path;
            be_q      <= big_endian;
            nb_q      <= nb;
            data_q    <= resp_m;
         end
      end
   end

   logic [31:0] arr_word;
   always_comb begin
      if (!be_q)             arr_word = arr_rdata;
      else if (nb_q == 3'd1) arr_word = {24'h0, arr_rdata[7:0]};
      else if (nb_q == 3'd2) arr_word = {16'h0, arr_rdata[7:0], arr_rdata[15:8]};
      else arr_word = {arr_rdata[7:0], arr_rdata[15:8], arr_rdata[23:16], arr_rdata[31:24]};
   end

   assign rd_valid = valid_q;
   assign mode_clr = clr_q;
   assign rd_data  = arr_sel_q ? (arr_word & size_mask(nb_q)) : data_q;
endmodule

// File: rtl/flash_rd_mux_chk.sv
`timescale 1ns/1ps
module flash_rd_mux_chk (
   input logic        clk,
   input logic        rst_n,
   input logic        rd_req,
   input logic [7:0]  rd_mode,
   input logic [1:0]  rd_size,
   input logic [7:0]  status,
   input logic        rd_valid,
   input logic [31:0] rd_data,
   input logic        mode_clr
);
   import frm_pkg::*;

   p_valid_after_req_r1: assert property (@(posedge clk) disable iff (!rst_n)
      rd_req |=> rd_valid);
   p_no_stray_valid_r1: assert property (@(posedge clk) disable iff (!rst_n)
      !rd_req |=> !rd_valid);
   p_narrow_upper_zero_r6: assert property (@(posedge clk) disable iff (!rst_n)
      rd_req && rd_size == 2'd0 |=> rd_data[31:8] == 24'h0);
   p_half_upper_zero_r6: assert property (@(posedge clk) disable iff (!rst_n)
      rd_req && rd_size == 2'd1 |=> rd_data[31:16] == 16'h0);
   p_status_byte_r4: assert property (@(posedge clk) disable iff (!rst_n)
      rd_req && rd_size == 2'd0 && is_status_mode(rd_mode) |=> rd_data == {24'h0, $past(status)});
   p_unknown_clears_r13: assert property (@(posedge clk) disable iff (!rst_n)
      rd_req && !is_known_mode(rd_mode) |=> mode_clr);
   p_clr_only_unknown_r13: assert property (@(posedge clk) disable iff (!rst_n)
      !(rd_req && !is_known_mode(rd_mode)) |=> !mode_clr);
endmodule

bind flash_rd_mux flash_rd_mux_chk chk_i (
   .clk(clk), .rst_n(rst_n), .rd_req(rd_req), .rd_mode(rd_mode), .rd_size(rd_size),
   .status(status), .rd_valid(rd_valid), .rd_data(rd_data), .mode_clr(mode_clr)
);

// File: tb/flash_rd_mux_tb_top.sv
`timescale 1ns/1ps
module flash_rd_mux_tb_top;
   logic clk = 1'b0;
   always #2.5 clk = ~clk;

   logic        rst_n, rd_req, big_endian, arr_rd_en, rd_valid, mode_clr;
   logic [15:0] rd_addr, arr_addr, id_mfr, id_dev;
   logic [1:0]  rd_size, bank_code, dev_code, max_code;
   logic [7:0]  rd_mode, status, id_aux0, id_aux1;
   logic [31:0] arr_rdata, rd_data;

   int checks = 0, errors = 0;
   bit done = 0;
   logic [7:0] mem [256];

   always @(posedge clk)
      if (arr_rd_en)
         arr_rdata <= {mem[arr_addr[7:0] + 8'd3], mem[arr_addr[7:0] + 8'd2],
                       mem[arr_addr[7:0] + 8'd1], mem[arr_addr[7:0]]};

   flash_rd_mux dut_i (
      .clk(clk), .rst_n(rst_n), .rd_req(rd_req), .rd_addr(rd_addr), .rd_size(rd_size),
      .rd_mode(rd_mode), .bank_code(bank_code), .dev_code(dev_code), .max_code(max_code),
      .big_endian(big_endian), .status(status), .id_mfr(id_mfr), .id_dev(id_dev),
      .id_aux0(id_aux0), .id_aux1(id_aux1), .arr_rd_en(arr_rd_en), .arr_addr(arr_addr),
      .arr_rdata(arr_rdata), .rd_valid(rd_valid), .rd_data(rd_data), .mode_clr(mode_clr)
   );

   task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp,
                      input string what);
      checks++;
      if (act !== exp) begin
         errors++;
         $display("FAIL %s %s actual=%08h expected=%08h", tag, what, act, exp);
      end
   endtask

   function automatic logic [7:0] tbl(input int i);
      case (i)
         'h10: return 8'h51;  'h11: return 8'h52;  'h12: return 8'h59;
         'h13: return 8'h01;  'h15: return 8'h31;  'h1B: return 8'h45;
         'h1C: return 8'h55;  'h1F: return 8'h07;  'h20: return 8'h07;
         'h21: return 8'h0A;  'h23: return 8'h04;  'h24: return 8'h04;
         'h25: return 8'h04;  'h27: return 8'h16;  'h28: return 8'h02;
         'h2A: return 8'h0B;  'h2C: return 8'h01;  'h2D: return 8'h3F;
         'h30: return 8'h01;  'h31: return 8'h50;  'h32: return 8'h52;
         'h33: return 8'h49;  'h34: return 8'h31;  'h35: return 8'h30;
         'h3F: return 8'h01;
         default: return 8'h00;
      endcase
   endfunction

   function automatic bit known(input logic [7:0] m);
      return m == 8'h00 || m == 8'h90 || m == 8'h98 || m == 8'h10 || m == 8'h20 ||
             m == 8'h28 || m == 8'h40 || m == 8'h50 || m == 8'h60 || m == 8'h70 || m == 8'hE8;
   endfunction

   function automatic logic [31:0] model(input logic [7:0] m, input int a, input int sz);
      int nb, bw, dlg, mlg, dw, idx, k, w, sa, wd;
      logic [31:0] d;
      logic [7:0] byt, t;
      logic [15:0] code;
      nb  = (sz == 0) ? 1 : (sz == 1) ? 2 : 4;
      bw  = 1 << int'(bank_code);
      dlg = int'(dev_code) - 1;
      mlg = (max_code == 2'd0) ? dlg : int'(max_code) - 1;
      dw  = (dlg < 0) ? 0 : (1 << dlg);
      d   = '0;
      if (!known(m) || m == 8'h00) begin
         for (int i = 0; i < nb; i++) begin
            byt = mem[(a + i) & 255];
            if (big_endian) d = d | (32'(byt) << (8 * (nb - 1 - i)));
            else            d = d | (32'(byt) << (8 * i));
         end
      end else if (m != 8'h90 && m != 8'h98) begin
         for (int b = 0; b < nb; b++)
            if (b % ((dw == 0) ? 2 : dw) == 0) d = d | (32'(status) << (8 * b));
      end else if (dw == 0) begin
         idx = (a & 255) >> int'(bank_code);
         if (m == 8'h90) begin
            code = (idx == 0) ? {id_mfr[7:0], id_dev[7:0]} : (idx == 1) ? {id_aux0, id_aux1} : 16'h0;
            d = (nb == 1) ? {24'h0, code[7:0]} : {16'h0, code};
         end else begin
            d = (idx > 'h52) ? 32'h0 : {24'h0, tbl(idx)};
         end
      end else begin
         for (int b = 0; b < nb; b++) begin
            k   = b / bw;
            w   = b % bw;
            sa  = (a + k * bw) & 16'hFFFF;
            idx = sa >> (int'(bank_code) + mlg - dlg);
            wd  = w % dw;
            if (m == 8'h90) begin
               code = ((idx & 255) == 0) ? id_mfr : ((idx & 255) == 1) ? id_dev : 16'h0;
               byt  = (wd < 2) ? code[8*wd +: 8] : 8'h00;
            end else begin
               t   = (idx > 'h52) ? 8'h00 : tbl(idx);
               byt = (dlg == mlg) ? ((wd == 0) ? t : 8'h00) : ((dw == 1) ? t : 8'h00);
            end
            d = d | (32'(byt) << (8 * b));
         end
      end
      return d;
   endfunction

   function automatic string tag_for(input logic [7:0] m, input int sz);
      int nb, bw;
      nb = (sz == 0) ? 1 : (sz == 1) ? 2 : 4;
      bw = 1 << int'(bank_code);
      if (!known(m)) return "R13";
      if (m == 8'h00) return big_endian ? "R3" : "R2";
      if (m != 8'h90 && m != 8'h98) return (dev_code == 2'd0) ? "R5" : "R4";
      if (dev_code == 2'd0) return "R11";
      if (nb > bw) return "R12";
      if (m == 8'h90) return "R10";
      return (max_code != 2'd0 && max_code != dev_code) ? "R9" : "R7";
   endfunction

   task automatic rd(input logic [7:0] m, input int a, input int sz, input string tag);
      logic [31:0] exp;
      @(negedge clk);
      rd_req  = 1'b1;
      rd_mode = m;
      rd_addr = 16'(a);
      rd_size = 2'(sz);
      status  = 8'((a * 3 + 'h81) & 255);
      exp     = model(m, a, sz);
      @(negedge clk);
      rd_req = 1'b0;
      chk("R1", {31'h0, rd_valid}, 32'h1, "valid after strobe");
      chk(tag, rd_data, exp, $sformatf("mode=%02h addr=%0h size=%0d bank=%0d dev=%0d max=%0d",
                                       m, a, sz, bank_code, dev_code, max_code));
      chk("R13", {31'h0, mode_clr}, {31'h0, !known(m)}, "mode clear pulse");
   endtask

   initial begin : watchdog
      repeat (190000) @(posedge clk);
      if (!done) begin
         checks++;
         errors++;
         $display("FAIL R1 watchdog expired actual=running expected=finished");
         $display("  CHECKS %0d ERRORS %0d", checks, errors);
         $finish;
      end
   end

   initial begin : main
      logic [7:0] modes [6];
      modes = '{8'h00, 8'h70, 8'h90, 8'h98, 8'h33, 8'hE8};
      for (int i = 0; i < 256; i++) mem[i] = 8'((i * 37 + 11) & 255);
      rst_n = 1'b0; rd_req = 1'b0; rd_addr = '0; rd_size = '0; rd_mode = '0;
      bank_code = '0; dev_code = 2'd1; max_code = '0; big_endian = 1'b0; status = '0;
      id_mfr = 16'h0089; id_dev = 16'h1234; id_aux0 = 8'hAB; id_aux1 = 8'hCD;
      repeat (3) @(negedge clk);
      chk("R1", {31'h0, rd_valid}, 32'h0, "valid in reset");
      chk("R13", {31'h0, mode_clr}, 32'h0, "clear in reset");
      rst_n = 1'b1;

      for (int b = 0; b < 3; b++)
         for (int d = 0; d < 4; d++)
            for (int mx = 0; mx < 4; mx++) begin
               if (d == 0 && mx != 0) continue;
               if (d > 0 && (d - 1) > b) continue;
               if (d > 0 && mx > 0 && mx < d) continue;
               bank_code  = 2'(b);
               dev_code   = 2'(d);
               max_code   = 2'(mx);
               big_endian = 1'((b + d + mx) & 1);
               for (int mi = 0; mi < 6; mi++)
                  for (int sz = 0; sz < 3; sz++)
                     for (int j = 0; j < 112; j++)
                        rd(modes[mi], (j < 16) ? j : (j - 16) * 17, sz, tag_for(modes[mi], sz));
            end

      // R8: index 0x90 would alias onto 0x10 ('Q') if not saturated
      bank_code = 2'd0; dev_code = 2'd1; max_code = 2'd1;
      rd(8'h98, 'h90, 0, "R8");
      rd(8'h98, 'h10, 0, "R7");
      // R6: legacy identifier reply trimmed to a single byte
      dev_code = 2'd0; max_code = 2'd0;
      rd(8'h90, 0, 0, "R6");
      // R1: no valid on an idle cycle
      @(negedge clk);
      chk("R1", {31'h0, rd_valid}, 32'h0, "idle cycle");

      done = 1;
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end
endmodule